// File: doc/BRIEF.md
# Voltage Sensor Access Sequencer

This block runs an on-chip voltage sensor through its core-driven access mode. After a single start command it turns on core control of the sensor, waits with the sensor held in reset, releases the reset, and shifts an 8-bit setup byte into the sensor over a serial bit line. While the setup byte is shifted it holds a configuration strobe high, and the strobe's falling edge starts the first conversion. The block then runs through a list of up to sixteen channel numbers. It places the next channel on the select lines ahead of each end-of-conversion, and it captures each 6-bit code when end-of-conversion falls.

Every captured code leaves the block on a one-cycle strobe. The strobe carries the channel that produced the code and the sensor's end-of-sequence flag from the same cycle. When the list is finished, the block turns core control off, puts the sensor back in reset and pulses a done flag. If a conversion never finishes, a programmable timeout stops the run, puts the sensor back in reset and raises a sticky error flag.

Top module: `vsense_seq`

## Requirements
- R1: After a start is accepted, the core-control output rises while the sensor reset stays high. The reset is released only after the core-control output has been high for WAIT_EN (default 2) clock cycles.
- R2: The configuration strobe rises only after the sensor reset has been low for WAIT_RST (default 2) cycles. The strobe is high only while core control is on and reset is low.
- R3: The configuration strobe stays high for exactly CFGW (8) cycles. During that window the serial bit line carries the setup byte that was latched at start, one bit per cycle, most significant bit first.
- R4: The channel select holds list entry 0 and does not change while the configuration strobe is high.
- R5: During conversions the channel select shows the following list entry. It changes only in the cycle after a capture, so it is stable at least one cycle before end-of-conversion rises.
- R6: A capture happens on the first cycle in which end-of-conversion is low after it was high. The result carries the data and end-of-sequence value from the last cycle in which end-of-conversion was high. The result strobe is high for one cycle, the cycle after that edge, and it carries the channel number of that conversion.
- R7: The channel list is a flat vector in which entry i sits at bits [4i+3:4i]. The entries are converted in index order, from entry 0 to entry count-1. Results leave in that order. A start with a count of 0 or a count above 16 is ignored.
- R8: The done pulse comes in the same cycle as the last result strobe. In that cycle busy is low, core control is off and the sensor reset is high.
- R9: Suppose the conversion state lasts tmo_i cycles without a capture. Then the error flag is set in the next cycle, and the block is idle with core control off and reset high. The error flag stays set until the next start is accepted.
- R10: Busy is high from the cycle after a start is accepted until done or error. A start that arrives while busy is ignored.
- R11: While reset is asserted and right after it is released, core control is off, the sensor reset is high, the strobes are low, and busy, done, error and the result strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start command, accepted when idle |
| cfg_i | input | CFGW (8) | Setup byte for the sensor, latched at start |
| chan_list_i | input | MAXCH*CHW (64) | Channel list, entry i at bits [4i+3:4i] |
| chan_cnt_i | input | CNTW (5) | Number of list entries to convert (1..16) |
| tmo_i | input | TOW (16) | Conversion timeout in cycles, latched at start |
| sn_en_o | output | 1 | Core-control enable to the sensor |
| sn_rst_o | output | 1 | Sensor reset, active high |
| sn_cfg_en_o | output | 1 | Configuration strobe |
| sn_cfg_bit_o | output | 1 | Serial setup bit |
| sn_chsel_o | output | CHW (4) | Channel select |
| sn_eoc_i | input | 1 | End of conversion from the sensor |
| sn_eos_i | input | 1 | End of sequence from the sensor |
| sn_data_i | input | DW (6) | Conversion code from the sensor |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at normal completion |
| err_o | output | 1 | Sticky conversion-timeout flag |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_chan_o | output | CHW (4) | Channel of the result |
| res_data_o | output | DW (6) | Conversion code of the result |
| res_eos_o | output | 1 | End-of-sequence flag captured with the result |

## Verification
The bench builds the block with its default parameters: sixteen list entries, two-cycle enable and reset waits, an 8-bit setup byte and a 16-bit timeout. At these values a full sixteen-entry list finishes in a few hundred cycles, so both list bounds (one entry and sixteen entries) and the rejected counts 0 and 17 are all reachable. The 16-bit timeout lets the bench set a short limit, 20 cycles, against a stalled sensor model and check the exact cycle at which the run is abandoned. A long limit, 200 cycles, never trips during normal runs.

// File: rtl/vsense_pkg.sv
package vsense_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EN_WAIT,
    ST_RST_WAIT,
    ST_CFG,
    ST_CONV
  } seq_state_t;
endpackage

// File: rtl/vsense_timer.sv
module vsense_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o;
    if (clr_i)             cnt_d = '0;
    else if (cnt_o != CMAX) cnt_d = cnt_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_d;
  end

  // R9: the timeout counter saturates rather than wrapping to zero
  assert_timer_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cnt_o == CMAX) |=> (cnt_o == CMAX));
endmodule

// File: rtl/vsense_cfg_shift.sv
module vsense_cfg_shift #(
  parameter int CFGW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [CFGW-1:0] data_i,
  input  logic            shift_i,
  output logic            bit_o
);
  localparam int SCW = $clog2(CFGW + 1);

  logic [CFGW-1:0] sh_q, sh_d;
  logic [SCW-1:0]  scnt_q, scnt_d;

  always_comb begin
    sh_d   = sh_q;
    scnt_d = scnt_q;
    if (load_i) begin
      sh_d   = data_i;
      scnt_d = '0;
    end else if (shift_i) begin
      sh_d   = {sh_q[CFGW-2:0], 1'b0};
      scnt_d = scnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      scnt_q <= '0;
    end else begin
      sh_q   <= sh_d;
      scnt_q <= scnt_d;
    end
  end

  assign bit_o = sh_q[CFGW-1];

  // R3: no more than CFGW bits leave per loaded byte
  assert_shift_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> (scnt_q < SCW'(CFGW)));
endmodule

// File: rtl/vsense_chan_list.sv
module vsense_chan_list #(
  parameter int MAXCH = 16,
  parameter int CHW   = 4,
  parameter int CNTW  = 5,
  parameter int IDXW  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [MAXCH*CHW-1:0] list_i,
  input  logic [CNTW-1:0]      cnt_i,
  input  logic                 adv_i,
  input  logic                 ahead_i,
  output logic [CHW-1:0]       chsel_o,
  output logic [CHW-1:0]       cur_o,
  output logic                 last_o
);
  logic [CHW-1:0]  ent [MAXCH];
  logic [IDXW-1:0] idx_q, idx_d, sel;
  logic [CNTW-1:0] cnt_q, idx_ext;
  logic            nxt_ok;

  for (genvar g = 0; g < MAXCH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent[g] <= '0;
      else if (load_i) ent[g] <= list_i[g*CHW +: CHW];
    end
  end

  always_comb begin
    idx_d = idx_q;
    if (load_i)     idx_d = '0;
    else if (adv_i) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      idx_q <= idx_d;
      if (load_i) cnt_q <= cnt_i;
    end
  end

  assign idx_ext = CNTW'(idx_q);
  assign nxt_ok  = (idx_ext + 1'b1) < cnt_q;
  assign sel     = (ahead_i && nxt_ok) ? IDXW'(idx_q + 1'b1) : idx_q;
  assign chsel_o = ent[sel];
  assign cur_o   = ent[idx_q];
  assign last_o  = (idx_ext == cnt_q - 1'b1);

  // R7: a capture never advances past the programmed count
  assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> (idx_ext < cnt_q));
endmodule

// File: rtl/vsense_seq.sv
module vsense_seq
  import vsense_pkg::*;
#(
  parameter int MAXCH    = 16,
  parameter int CHW      = 4,
  parameter int DW       = 6,
  parameter int CFGW     = 8,
  parameter int TOW      = 16,
  parameter int WAIT_EN  = 2,
  parameter int WAIT_RST = 2,
  localparam int CNTW    = $clog2(MAXCH + 1),
  localparam int IDXW    = $clog2(MAXCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CFGW-1:0]      cfg_i,
  input  logic [MAXCH*CHW-1:0] chan_list_i,
  input  logic [CNTW-1:0]      chan_cnt_i,
  input  logic [TOW-1:0]       tmo_i,
  output logic                 sn_en_o,
  output logic                 sn_rst_o,
  output logic                 sn_cfg_en_o,
  output logic                 sn_cfg_bit_o,
  output logic [CHW-1:0]       sn_chsel_o,
  input  logic                 sn_eoc_i,
  input  logic                 sn_eos_i,
  input  logic [DW-1:0]        sn_data_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic                 res_valid_o,
  output logic [CHW-1:0]       res_chan_o,
  output logic [DW-1:0]        res_data_o,
  output logic                 res_eos_o
);
  localparam logic [TOW-1:0]  EN_LAST  = TOW'(WAIT_EN - 1);
  localparam logic [TOW-1:0]  RST_LAST = TOW'(WAIT_RST - 1);
  localparam logic [TOW-1:0]  CFG_LAST = TOW'(CFGW - 1);
  localparam logic [CNTW-1:0] CNT_MAX  = CNTW'(MAXCH);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rsync;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_s = rsync[1];

  seq_state_t     state_q, state_d;
  logic [TOW-1:0] t, tmo_q;
  logic           accept, cnt_ok, cap, fin, tmo_hit, tmr_clr;
  logic           eoc_q, eos_q;
  logic [DW-1:0]  data_q;
  logic [CHW-1:0] cur_ch;
  logic           last_ch;

  assign cnt_ok = (chan_cnt_i != '0) && (chan_cnt_i <= CNT_MAX);
  assign accept = (state_q == ST_IDLE) && start_i && cnt_ok;
  assign cap    = (state_q == ST_CONV) && eoc_q && !sn_eoc_i;

  always_comb begin
    state_d = state_q;
    fin     = 1'b0;
    tmo_hit = 1'b0;
    unique case (state_q)
      ST_IDLE:     if (accept)         state_d = ST_EN_WAIT;
      ST_EN_WAIT:  if (t == EN_LAST)   state_d = ST_RST_WAIT;
      ST_RST_WAIT: if (t == RST_LAST)  state_d = ST_CFG;
      ST_CFG:      if (t == CFG_LAST)  state_d = ST_CONV;
      ST_CONV: begin
        if (cap && last_ch) begin
          state_d = ST_IDLE;
          fin     = 1'b1;
        end else if (!cap && (t == tmo_q - 1'b1)) begin
          state_d = ST_IDLE;
          tmo_hit = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_clr = (state_d != state_q) || cap;

  vsense_timer #(.W(TOW)) u_timer (
    .clk   (clk),
    .rst_n (rst_s),
    .clr_i (tmr_clr),
    .cnt_o (t)
  );

  vsense_cfg_shift #(.CFGW(CFGW)) u_shift (
    .clk     (clk),
    .rst_n   (rst_s),
    .load_i  (accept),
    .data_i  (cfg_i),
    .shift_i (state_q == ST_CFG),
    .bit_o   (sn_cfg_bit_o)
  );

  vsense_chan_list #(.MAXCH(MAXCH), .CHW(CHW), .CNTW(CNTW), .IDXW(IDXW)) u_list (
    .clk     (clk),
    .rst_n   (rst_s),
    .load_i  (accept),
    .list_i  (chan_list_i),
    .cnt_i   (chan_cnt_i),
    .adv_i   (cap),
    .ahead_i (state_q == ST_CONV),
    .chsel_o (sn_chsel_o),
    .cur_o   (cur_ch),
    .last_o  (last_ch)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q     <= ST_IDLE;
      tmo_q       <= '0;
      eoc_q       <= 1'b0;
      eos_q       <= 1'b0;
      data_q      <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      res_valid_o <= 1'b0;
      res_chan_o  <= '0;
      res_data_o  <= '0;
      res_eos_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      eoc_q       <= sn_eoc_i;
      eos_q       <= sn_eos_i;
      data_q      <= sn_data_i;
      done_o      <= fin;
      res_valid_o <= cap;
      if (accept)       tmo_q <= tmo_i;
      if (accept)       err_o <= 1'b0;
      else if (tmo_hit) err_o <= 1'b1;
      if (cap) begin
        res_chan_o <= cur_ch;
        res_data_o <= data_q;
        res_eos_o  <= eos_q;
      end
    end
  end

  assign sn_en_o     = (state_q != ST_IDLE);
  assign sn_rst_o    = (state_q == ST_IDLE) || (state_q == ST_EN_WAIT);
  assign sn_cfg_en_o = (state_q == ST_CFG);
  assign busy_o      = (state_q != ST_IDLE);

  // R1: reset released only with core control on for the wait
  assert_rst_after_en_R1: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(sn_rst_o) |-> (sn_en_o && $past(sn_en_o, 2)));
  // R2: configuration begins only after reset has been low long enough
  assert_cfg_after_rst_R2: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(sn_cfg_en_o) |-> (!sn_rst_o && !$past(sn_rst_o, 2)));
  // R4: channel select frozen during the configuration window
  assert_chsel_hold_cfg_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (sn_cfg_en_o && $past(sn_cfg_en_o)) |-> $stable(sn_chsel_o));
  // R6: a result follows a falling end-of-conversion
  assert_capture_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_s)
    res_valid_o |-> ($past(eoc_q) && !$past(sn_eoc_i)));
  // R8: done leaves the sensor disabled and in reset
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_s)
    done_o |-> (!busy_o && !sn_en_o && sn_rst_o && res_valid_o));
  // R9: a timeout leaves the sensor in reset
  assert_err_reset_R9: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(err_o) |-> (sn_rst_o && !busy_o && !done_o));
  // R10: busy ends only through done or error
  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(busy_o) |-> (done_o || err_o));
endmodule

// File: tb/tb_vsense_seq.sv
`timescale 1ns/1ps
module tb_vsense_seq;
  localparam int CONV_T  = 10;
  localparam int EOC_LEN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  cfg_i = '0;
  logic [63:0] chan_list_i = '0;
  logic [4:0]  chan_cnt_i = '0;
  logic [15:0] tmo_i = 16'd200;
  logic        sn_en_o, sn_rst_o, sn_cfg_en_o, sn_cfg_bit_o;
  logic [3:0]  sn_chsel_o;
  logic        sn_eoc_i = 1'b0, sn_eos_i = 1'b0;
  logic [5:0]  sn_data_i = '0;
  logic        busy_o, done_o, err_o, res_valid_o, res_eos_o;
  logic [3:0]  res_chan_o;
  logic [5:0]  res_data_o;

  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  vsense_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i),
    .chan_list_i(chan_list_i), .chan_cnt_i(chan_cnt_i), .tmo_i(tmo_i),
    .sn_en_o(sn_en_o), .sn_rst_o(sn_rst_o), .sn_cfg_en_o(sn_cfg_en_o),
    .sn_cfg_bit_o(sn_cfg_bit_o), .sn_chsel_o(sn_chsel_o),
    .sn_eoc_i(sn_eoc_i), .sn_eos_i(sn_eos_i), .sn_data_i(sn_data_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .res_valid_o(res_valid_o), .res_chan_o(res_chan_o),
    .res_data_o(res_data_o), .res_eos_o(res_eos_o)
  );

  function automatic logic [5:0] mdat(input logic [3:0] ch, input logic [7:0] c);
    return 6'(int'(ch) * 5 + int'(c));
  endfunction

  // behavioural sensor model with protocol monitors
  logic       dead = 1'b0;
  logic       prev_rst = 1'b1, prev_cfg = 1'b0;
  int         en_age = 0, rlow_age = 0, cfg_len = 0, timer = 0;
  int         v_r1 = 0, v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0;
  logic [7:0] m_sh = '0, got_cfg = '0;
  logic [3:0] cfg_ch = '0, cur_ch = '0, next_ch = '0, chsel_prev = '0;
  logic       running = 1'b0, ph = 1'b0;

  always @(posedge clk) begin
    prev_rst   <= sn_rst_o;
    prev_cfg   <= sn_cfg_en_o;
    chsel_prev <= sn_chsel_o;
    en_age     <= sn_en_o ? en_age + 1 : 0;
    rlow_age   <= sn_rst_o ? 0 : rlow_age + 1;
    if (prev_rst && !sn_rst_o && en_age < 2) v_r1 <= v_r1 + 1;
    if (!prev_cfg && sn_cfg_en_o && (rlow_age < 2 || !sn_en_o)) v_r2 <= v_r2 + 1;
    if (sn_cfg_en_o) begin
      cfg_len <= cfg_len + 1;
      m_sh    <= {m_sh[6:0], sn_cfg_bit_o};
      if (prev_cfg && sn_chsel_o != cfg_ch) v_r4 <= v_r4 + 1;
      cfg_ch  <= sn_chsel_o;
    end
    if (prev_cfg && !sn_cfg_en_o) begin
      if (cfg_len != 8) v_r3 <= v_r3 + 1;
      cfg_len <= 0;
      got_cfg <= m_sh;
      cur_ch  <= cfg_ch;
      running <= 1'b1;
      ph      <= 1'b0;
      timer   <= CONV_T;
    end else if (running && !dead) begin
      if (!ph) begin
        if (timer == 0) begin
          if (sn_chsel_o != chsel_prev) v_r5 <= v_r5 + 1;
          sn_eoc_i  <= 1'b1;
          sn_data_i <= mdat(cur_ch, got_cfg);
          sn_eos_i  <= (cur_ch == 4'hF);
          next_ch   <= sn_chsel_o;
          ph        <= 1'b1;
          timer     <= EOC_LEN - 1;
        end else timer <= timer - 1;
      end else begin
        if (timer == 0) begin
          sn_eoc_i  <= 1'b0;
          sn_eos_i  <= 1'b0;
          sn_data_i <= '0;
          cur_ch    <= next_ch;
          ph        <= 1'b0;
          timer     <= CONV_T;
        end else timer <= timer - 1;
      end
    end
    if (!sn_en_o || sn_rst_o) begin
      running  <= 1'b0;
      ph       <= 1'b0;
      sn_eoc_i <= 1'b0;
      sn_eos_i <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_seq(input logic [7:0] c, input logic [4:0] n,
                         input logic [63:0] l, input bit poke);
    int got = 0, cyc = 0, gaps = 0;
    bit fin = 0;
    @(negedge clk);
    start_i = 1'b1; cfg_i = c; chan_cnt_i = n; chan_list_i = l;
    @(negedge clk);
    start_i = 1'b0; cfg_i = '0; chan_cnt_i = '0; chan_list_i = '0;
    chk(busy_o == 1'b1, "R10", "busy after accept", busy_o, 1);
    chk(err_o == 1'b0, "R9", "error cleared by start", err_o, 0);
    while (!fin && cyc < 5000) begin
      if (poke && cyc == 30) begin
        start_i = 1'b1; cfg_i = ~c; chan_cnt_i = 5'd1; chan_list_i = 64'h5;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (res_valid_o) begin
        logic [3:0] ech;
        ech = (got < int'(n)) ? l[got*4 +: 4] : 4'h0;
        chk(got < int'(n), "R7", "result count bound", got, n);
        chk(res_chan_o == ech, "R7", "result channel order", res_chan_o, ech);
        chk(res_data_o == mdat(ech, c), "R6", "result data", res_data_o, mdat(ech, c));
        chk(res_eos_o == (ech == 4'hF), "R6", "result eos", res_eos_o, (ech == 4'hF));
        got++;
      end
      if (done_o) begin
        fin = 1;
        chk(res_valid_o == 1'b1, "R8", "done with last result", res_valid_o, 1);
      end else if (!busy_o) gaps++;
    end
    start_i = 1'b0;
    chk(fin, "R8", "done seen", fin, 1);
    chk(got == int'(n), "R7", "results delivered", got, n);
    chk(gaps == 0, "R10", "busy gaps", gaps, 0);
    chk(!sn_en_o && sn_rst_o && !busy_o, "R8", "idle after done",
        {sn_en_o, sn_rst_o, busy_o}, 3'b010);
    chk(got_cfg == c, "R3", "setup byte shifted MSB first", got_cfg, c);
    chk(v_r1 == 0, "R1", "enable wait violations", v_r1, 0);
    chk(v_r2 == 0, "R2", "reset wait violations", v_r2, 0);
    chk(v_r3 == 0, "R3", "config window length violations", v_r3, 0);
    chk(v_r4 == 0, "R4", "chsel moved in config window", v_r4, 0);
    chk(v_r5 == 0, "R5", "chsel moved before eoc", v_r5, 0);
    chk(err_o == 1'b0, "R9", "no timeout on good run", err_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R8", "done is one cycle", done_o, 0);
  endtask

  task automatic try_bad_count(input logic [4:0] n);
    @(negedge clk);
    start_i = 1'b1; cfg_i = 8'h77; chan_cnt_i = n; chan_list_i = 64'h1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy_o && !sn_en_o && sn_rst_o, "R7", "bad count ignored",
        {busy_o, sn_en_o, sn_rst_o}, 3'b001);
  endtask

  // entry: {cfg, count, list}
  localparam logic [76:0] VEC [4] = '{
    {8'hA5, 5'd3,  64'h0000_0000_0000_0F72},
    {8'h3C, 5'd1,  64'h0000_0000_0000_0009},
    {8'hFF, 5'd16, 64'hFEDC_BA98_7654_3210},
    {8'h01, 5'd5,  64'h0000_0000_000F_F0A3}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: state while reset is held
    chk(!sn_en_o && sn_rst_o && !sn_cfg_en_o && !busy_o && !done_o && !err_o && !res_valid_o,
        "R11", "outputs in reset", {sn_en_o, sn_rst_o, sn_cfg_en_o, busy_o}, 4'b0100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sn_en_o && sn_rst_o && !sn_cfg_en_o && !busy_o && !done_o && !err_o && !res_valid_o,
        "R11", "outputs after reset", {sn_en_o, sn_rst_o, sn_cfg_en_o, busy_o}, 4'b0100);

    for (int i = 0; i < 4; i++) begin
      run_seq(VEC[i][76:69], VEC[i][68:64], VEC[i][63:0], 1'b0);
    end

    // R10: a start while busy is ignored
    run_seq(8'h5A, 5'd3, 64'h0000_0000_0000_0C41, 1'b1);

    // R7: counts outside 1..16 are refused
    try_bad_count(5'd0);
    try_bad_count(5'd17);

    // R9: stalled sensor trips the timeout after exactly tmo_i cycles
    begin
      int k = 0;
      bit seen_cfg = 0;
      dead = 1'b1;
      tmo_i = 16'd20;
      @(negedge clk);
      start_i = 1'b1; cfg_i = 8'h11; chan_cnt_i = 5'd2; chan_list_i = 64'h32;
      @(negedge clk);
      start_i = 1'b0;
      while (!(seen_cfg && !sn_cfg_en_o) && k < 100) begin
        if (sn_cfg_en_o) seen_cfg = 1;
        @(negedge clk);
        k++;
      end
      k = 0;
      while (!err_o && k < 200) begin
        chk(!res_valid_o, "R9", "no result while stalled", res_valid_o, 0);
        @(negedge clk);
        k++;
      end
      chk(k == 20, "R9", "timeout cycle count", k, 20);
      chk(sn_rst_o && !sn_en_o && !busy_o && !done_o, "R9", "idle in reset after timeout",
          {sn_rst_o, sn_en_o, busy_o, done_o}, 4'b1000);
      repeat (3) @(negedge clk);
      chk(err_o == 1'b1, "R9", "error flag held", err_o, 1);
      dead = 1'b0;
      tmo_i = 16'd200;
    end

    // R9: next accepted start clears the flag and runs normally
    run_seq(8'hC3, 5'd2, 64'h0000_0000_0000_00E6, 1'b0);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule